// File: doc/BRIEF.md
# Almost-Full / Almost-Empty Offset Register

This block holds the two threshold offsets that a FIFO's flag logic compares against its fill level: one for the almost-empty flag and one for the almost-full flag. When master reset is asserted, both offsets take one of eight preset values. A 3-bit preset select input picks the value. Software or a host controller can later replace either value through one of two paths on the write clock.

The first path is a parallel path. Data arrives in chunks on a 9-bit data input, qualified by a load strobe together with write enable. Chunks are either 8 or 9 bits wide, as chosen by a mode input. The second path is a serial path, in which one bit is shifted in per cycle while the serial enable is high. Both paths fill the almost-empty offset first and then the almost-full offset, starting from the least significant end.

A partial reset restarts both load sequences but keeps the stored offsets. A master reset discards everything that was programmed. Both offsets are presented continuously on output ports for the flag comparators.

Top module: `flag_offset_regs`

## Requirements
- R1: While rst_ni is low, and after it rises, both offsets equal 2^(PRESET_LOG2+preset_sel_i)−1. With the default PRESET_LOG2=3, this gives 7, 15, 31, 63, 127, 255, 511 and 1023 for select values 0 to 7.
- R2: With chunk9_i=0, each cycle that has load_i=1 and wen_i=1 writes data_i[7:0] into the next chunk. The chunk order is almost-empty bits [7:0], then [15:8], then [16], followed by the same three chunks of the almost-full offset. The third chunk of each offset uses data_i[0] only.
- R3: With chunk9_i=1, each load cycle writes data_i[8:0] into the next chunk. The chunk order is almost-empty bits [8:0], then [16:9] (from data_i[7:0]), followed by the same two chunks of the almost-full offset.
- R4: After the last chunk of the almost-full offset, the next load cycle writes the first chunk of the almost-empty offset again.
- R5: A cycle with load_i=1 and wen_i=0, or with wen_i=1 and load_i=0, and with sden_i=0, changes neither offset.
- R6: Each cycle that has sden_i=1 and no parallel load writes sdi_i into one bit. The bit order is almost-empty bits 0 to 16, then almost-full bits 0 to 16.
- R7: After 34 serial bits, further serial cycles change neither offset until the next partial or master reset.
- R8: A cycle with prst_i=1 changes neither offset, even if loads are requested. It returns both the parallel sequence and the serial sequence to their first position.
- R9: A master reset discards programmed values and restores the preset of R1.
- R10: When a parallel load and a serial bit occur in the same cycle, only the parallel load takes effect, and the serial position does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Write clock |
| rst_ni | input | 1 | Active-low asynchronous master reset |
| prst_i | input | 1 | Synchronous partial reset (restarts load sequencing) |
| preset_sel_i | input | 3 | Preset choice applied during master reset |
| wen_i | input | 1 | Write enable, qualifies parallel load |
| load_i | input | 1 | Parallel offset load strobe |
| chunk9_i | input | 1 | Parallel chunk width: 0 = 8 bits, 1 = 9 bits |
| data_i | input | 9 | Parallel load data |
| sden_i | input | 1 | Serial load enable |
| sdi_i | input | 1 | Serial load data bit |
| ae_ofs_o | output | OFS_W (17) | Almost-empty offset |
| af_ofs_o | output | OFS_W (17) | Almost-full offset |

## Verification
The bench builds the block with its defaults: OFS_W=17 and PRESET_LOG2=3. At this size the full 34-bit serial sequence, every 8-bit and 9-bit chunk position, and the short single-bit top chunk can all be reached within a few hundred cycles. The bench sweeps all eight preset selections. It then walks both chunk widths through their complete sequences and through the wrap. Expected offsets are rebuilt arithmetically from the chunk and bit positions given in the requirements.

// File: rtl/fo_pkg.sv
package fo_pkg;
  function automatic logic [31:0] preset_value(input int log2_base, input logic [2:0] sel);
    return (32'd1 << (log2_base + int'(sel))) - 32'd1;
  endfunction
endpackage

// File: rtl/fo_preset_rom.sv
module fo_preset_rom #(
  parameter int OFS_W       = 17,
  parameter int PRESET_LOG2 = 3
) (
  input  logic [2:0]       sel_i,
  output logic [OFS_W-1:0] ae_o,
  output logic [OFS_W-1:0] af_o
);
  logic [31:0] val;
  always_comb begin
    val  = fo_pkg::preset_value(PRESET_LOG2, sel_i);
    ae_o = val[OFS_W-1:0];
    af_o = val[OFS_W-1:0];
  end
endmodule

// File: rtl/fo_par_loader.sv
module fo_par_loader #(
  parameter int OFS_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prst_i,
  input  logic             strobe_i,
  input  logic             chunk9_i,
  input  logic [8:0]       data_i,
  output logic             we_o,
  output logic             sel_af_o,
  output logic [OFS_W-1:0] mask_o,
  output logic [OFS_W-1:0] val_o
);
  localparam int NCH8 = (OFS_W + 7) / 8;
  localparam int NCH9 = (OFS_W + 8) / 9;
  localparam int CW   = $clog2(2 * NCH8 + 1);
  localparam int LW   = $clog2(OFS_W + 10);

  logic [CW-1:0] cnt_q, nch, last, cidx;
  logic [LW-1:0] lsb;
  logic [8:0]    dmask;

  always_comb begin
    nch      = chunk9_i ? CW'(NCH9) : CW'(NCH8);
    last     = nch + nch - CW'(1);
    sel_af_o = (cnt_q >= nch);
    cidx     = sel_af_o ? cnt_q - nch : cnt_q;
    lsb      = chunk9_i ? LW'(cidx) * LW'(9) : LW'(cidx) * LW'(8);
    dmask    = chunk9_i ? 9'h1FF : 9'h0FF;
    mask_o   = OFS_W'(dmask) << lsb;
    val_o    = OFS_W'(data_i & dmask) << lsb;
    we_o     = strobe_i & ~prst_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (prst_i)   cnt_q <= '0;
    else if (strobe_i) cnt_q <= (cnt_q >= last) ? '0 : cnt_q + CW'(1);
  end
endmodule

// File: rtl/fo_ser_loader.sv
module fo_ser_loader #(
  parameter int OFS_W = 17
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prst_i,
  input  logic             shift_i,
  input  logic             block_i,
  output logic             we_o,
  output logic             sel_af_o,
  output logic [OFS_W-1:0] onehot_o
);
  localparam int SW = $clog2(2 * OFS_W + 1);
  localparam int BW = $clog2(OFS_W);

  logic [SW-1:0] cnt_q;
  logic [BW-1:0] bit_idx;
  logic          done;

  always_comb begin
    done     = (cnt_q == SW'(2 * OFS_W));
    sel_af_o = (cnt_q >= SW'(OFS_W));
    bit_idx  = sel_af_o ? BW'(cnt_q - SW'(OFS_W)) : BW'(cnt_q);
    onehot_o = OFS_W'(1) << bit_idx;
    we_o     = shift_i & ~block_i & ~prst_i & ~done;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (prst_i) cnt_q <= '0;
    else if (we_o)   cnt_q <= cnt_q + SW'(1);
  end
endmodule

// File: rtl/flag_offset_regs.sv
module flag_offset_regs #(
  parameter int OFS_W       = 17,
  parameter int PRESET_LOG2 = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             prst_i,
  input  logic [2:0]       preset_sel_i,
  input  logic             wen_i,
  input  logic             load_i,
  input  logic             chunk9_i,
  input  logic [8:0]       data_i,
  input  logic             sden_i,
  input  logic             sdi_i,
  output logic [OFS_W-1:0] ae_ofs_o,
  output logic [OFS_W-1:0] af_ofs_o
);
  logic [OFS_W-1:0] ae_q, af_q, ae_pre, af_pre;
  logic [OFS_W-1:0] p_mask, p_val, s_onehot;
  logic             p_we, p_af, s_we, s_af, strobe;

  assign strobe = load_i & wen_i;

  fo_preset_rom #(.OFS_W(OFS_W), .PRESET_LOG2(PRESET_LOG2)) u_rom (
    .sel_i(preset_sel_i), .ae_o(ae_pre), .af_o(af_pre)
  );

  fo_par_loader #(.OFS_W(OFS_W)) u_par (
    .clk_i(clk_i), .rst_ni(rst_ni), .prst_i(prst_i), .strobe_i(strobe),
    .chunk9_i(chunk9_i), .data_i(data_i), .we_o(p_we), .sel_af_o(p_af),
    .mask_o(p_mask), .val_o(p_val)
  );

  fo_ser_loader #(.OFS_W(OFS_W)) u_ser (
    .clk_i(clk_i), .rst_ni(rst_ni), .prst_i(prst_i), .shift_i(sden_i),
    .block_i(strobe), .we_o(s_we), .sel_af_o(s_af), .onehot_o(s_onehot)
  );

  // preset pins must be stable while rst_ni is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_q <= ae_pre;
      af_q <= af_pre;
    end else if (p_we) begin
      if (p_af) af_q <= (af_q & ~p_mask) | p_val;
      else      ae_q <= (ae_q & ~p_mask) | p_val;
    end else if (s_we) begin
      if (s_af) af_q <= sdi_i ? (af_q | s_onehot) : (af_q & ~s_onehot);
      else      ae_q <= sdi_i ? (ae_q | s_onehot) : (ae_q & ~s_onehot);
    end
  end

  assign ae_ofs_o = ae_q;
  assign af_ofs_o = af_q;
endmodule

// File: rtl/fo_offset_chk.sv
module fo_offset_chk #(
  parameter int OFS_W = 17
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             prst_i,
  input logic             wen_i,
  input logic             load_i,
  input logic             sden_i,
  input logic [OFS_W-1:0] ae_ofs_o,
  input logic [OFS_W-1:0] af_ofs_o
);
  a_r5_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(load_i && wen_i) && !sden_i) |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

  a_r8_prst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prst_i |=> ($stable(ae_ofs_o) && $stable(af_ofs_o)));

  a_r2_par_single_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && wen_i) |=> ($stable(ae_ofs_o) || $stable(af_ofs_o)));

  a_r6_ser_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sden_i && !(load_i && wen_i)) |=>
      (($countones(ae_ofs_o ^ $past(ae_ofs_o)) + $countones(af_ofs_o ^ $past(af_ofs_o))) <= 1));
endmodule

bind flag_offset_regs fo_offset_chk #(.OFS_W(OFS_W)) u_offset_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .prst_i(prst_i), .wen_i(wen_i),
  .load_i(load_i), .sden_i(sden_i), .ae_ofs_o(ae_ofs_o), .af_ofs_o(af_ofs_o)
);

// File: tb/flag_offset_regs_tb_top.sv
`timescale 1ns/1ps
module flag_offset_regs_tb_top;
  localparam int W = 17;
  logic clk = 0, rst_n = 0, prst = 0, wen = 0, load = 0, c9 = 0, sden = 0, sdi = 0;
  logic [2:0] sel = 0;
  logic [8:0] data = 0;
  logic [W-1:0] ae, af, ae_e, af_e;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  flag_offset_regs dut_i (
    .clk_i(clk), .rst_ni(rst_n), .prst_i(prst), .preset_sel_i(sel), .wen_i(wen),
    .load_i(load), .chunk9_i(c9), .data_i(data), .sden_i(sden), .sdi_i(sdi),
    .ae_ofs_o(ae), .af_ofs_o(af)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_both(input string req);
    chk(req, ae, ae_e);
    chk(req, af, af_e);
  endtask

  function automatic logic [W-1:0] put(input logic [W-1:0] v, input int lsb, input int w,
                                      input logic [8:0] d);
    for (int b = 0; b < w; b++) if (lsb + b < W) v[lsb + b] = d[b];
    return v;
  endfunction

  task automatic cyc(input logic ld, input logic we, input logic sd, input logic sb,
                     input logic [8:0] d, input logic pr);
    @(negedge clk);
    load = ld; wen = we; sden = sd; sdi = sb; data = d; prst = pr;
    @(negedge clk);
    load = 0; wen = 0; sden = 0; sdi = 0; data = 0; prst = 0;
  endtask

  task automatic mreset(input logic [2:0] s);
    @(negedge clk);
    rst_n = 0; sel = s;
    #1;
    ae_e = W'((32'd1 << (3 + s)) - 1);
    af_e = ae_e;
    chk_both("R1 during reset");
    @(negedge clk);
    rst_n = 1;
    #1;
  endtask

  // parallel load modelled from chunk index
  task automatic par_load(input int idx, input logic [8:0] d);
    int nch, w, c;
    w = c9 ? 9 : 8;
    nch = c9 ? 2 : 3;
    c = idx % nch;
    if (idx / nch == 0) ae_e = put(ae_e, c * w, w, d);
    else                af_e = put(af_e, c * w, w, d);
    cyc(1, 1, 0, 0, d, 0);
  endtask

  initial begin
    // R1: sweep all presets
    for (int s = 0; s < 8; s++) begin
      mreset(3'(s));
      chk_both("R1 after reset");
    end
    mreset(3'd2);

    // R5: half-qualified strobes
    cyc(1, 0, 0, 0, 9'h1AA, 0);
    chk_both("R5 load without wen");
    cyc(0, 1, 0, 0, 9'h155, 0);
    chk_both("R5 wen without load");

    // R2: 8-bit chunks, full sequence with per-step checks
    c9 = 0;
    for (int k = 0; k < 6; k++) begin
      par_load(k, 9'(9'h1A5 + 9'(k * 37)));
      chk_both("R2 8-bit chunk");
    end
    // R4: wrap to first almost-empty chunk
    par_load(0, 9'h0C3);
    chk_both("R4 wrap");

    // R8: partial reset holds values, restarts sequence
    cyc(1, 1, 1, 1, 9'h1FF, 1);
    chk_both("R8 prst holds");
    par_load(0, 9'h05A);
    chk_both("R8 restart at first chunk");

    // R3: 9-bit chunks
    cyc(0, 0, 0, 0, 0, 1);
    c9 = 1;
    for (int k = 0; k < 4; k++) begin
      par_load(k, 9'(9'h0F1 + 9'(k * 101)));
      chk_both("R3 9-bit chunk");
    end
    par_load(0, 9'h1E7);
    chk_both("R4 wrap 9-bit");
    c9 = 0;

    // R6: full serial sequence
    cyc(0, 0, 0, 0, 0, 1);
    begin
      logic [W-1:0] ta, tf;
      ta = 17'h1A5C3; tf = 17'h0E71B;
      for (int k = 0; k < 2 * W; k++) begin
        logic b;
        b = (k < W) ? ta[k] : tf[k - W];
        if (k < W) ae_e[k] = b; else af_e[k - W] = b;
        cyc(0, 0, 1, b, 0, 0);
        if (k == W - 1 || k == 2 * W - 1) chk_both("R6 serial fill");
      end
      chk("R6 ae value", ae, ta);
      chk("R6 af value", af, tf);
    end

    // R7: extra serial bits ignored
    for (int k = 0; k < 4; k++) cyc(0, 0, 1, ~ae_e[k], 0, 0);
    chk_both("R7 serial done");
    cyc(0, 0, 0, 0, 0, 1);
    ae_e[0] = ~ae_e[0];
    cyc(0, 0, 1, ae_e[0], 0, 0);
    chk_both("R7 serial restarts after prst");

    // R10: parallel wins, serial position not consumed
    cyc(0, 0, 0, 0, 0, 1);
    ae_e = put(ae_e, 0, 8, 9'h03C);
    cyc(1, 1, 1, 1, 9'h03C, 0);
    chk_both("R10 parallel priority");
    ae_e[0] = 1'b1;
    cyc(0, 0, 1, 1, 0, 0);
    chk_both("R10 serial still at bit 0");

    // R9: master reset discards programming
    mreset(3'd5);
    chk_both("R9 preset restored");
    par_load(0, 9'h0AB);
    chk_both("R9 sequence restarted");

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule